// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This block gathers the twelve interrupt sources of an I2C controller into one place. Ten of the sources are events: a one-cycle pulse from the controller core sets a sticky bit. The other two follow FIFO threshold levels. Software reads a raw status word and a masked status word, which is the raw word ANDed with a mask register. It also reads a register that records why a transmission was aborted. The block drives one registered interrupt line, which is high whenever any masked bit is set.

Each sticky source has its own clear register, and a read of that register clears only that source. An event that arrives between software's status read and its clear is therefore not lost. A second, combined clear register clears every sticky bit in one read. The abort-reason register belongs to the abort interrupt: any read that clears the abort bit also clears the reasons.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the raw status, the mask, the abort reasons and `irq` are all zero.
- R2: A pulse on `evt_in[i]` sets raw bit i on the following cycle for every sticky source, and the bit holds until it is cleared. The bit positions are: rx underflow 0, rx overflow 1, rx threshold 2, tx overflow 3, tx threshold 4, read request 5, tx abort 6, rx done 7, activity 8, stop seen 9, start seen 10, general call 11.
- R3: Offset 0x2C reads raw AND mask in bits 11:0. Offset 0x30 reads and writes the mask in bits 11:0. Offset 0x34 reads the raw status.
- R4: A read of a source's own clear register returns that bit in bit 0 and then clears only that bit. The registers sit at 0x44 to 0x68 in steps of 4, in this order: bit 0, 1, 3, 5, 6, 7, 8, 9, 10, 11.
- R5: A read of offset 0x40 returns in bit 0 the OR of the sticky bits, then clears all of them.
- R6: Bits 2 and 4 follow `rx_full_lvl` and `tx_empty_lvl` one cycle later. Clear reads do not change them, and `evt_in[2]` and `evt_in[4]` have no effect.
- R7: When an event pulse and a clear of the same bit fall in the same cycle, the bit stays set.
- R8: On a tx-abort pulse, `abrt_cause` bits 0-5, 7 and 9-12 are ORed into the abort-reason register at offset 0x80. Bits 6, 8 and any bit above 12 always read zero.
- R9: A read of 0x54 or 0x40 clears the abort reasons. A cause that arrives with a tx-abort pulse in that same cycle is kept.
- R10: `irq` goes high one cycle after the masked status becomes nonzero, and low one cycle after it becomes zero.
- R11: Writes anywhere other than 0x30 change nothing. Reads of unmapped offsets return zero and clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read strobe; clear side effects happen at the clock edge |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, valid in the same cycle |
| evt_in | input | 12 | Event pulses, one per source bit |
| rx_full_lvl | input | 1 | Rx threshold level condition |
| tx_empty_lvl | input | 1 | Tx threshold level condition |
| abrt_cause | input | 13 | Abort causes, sampled with `evt_in[6]` |
| irq | output | 1 | Registered interrupt request |

## Verification
A sticky bit that is lost or not cleared shows up at the raw status offset on the first read after the event or clear. It also moves `irq` exactly one cycle later. A clear decode that hits the wrong slot leaves a bit set or wipes out a neighbour, so the tests set pairs of bits and clear one of them. A missed abort-reason clear or OR shows up on the next read of 0x80. A set/clear priority error shows up only when both land in the same cycle, so that case is driven on purpose.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NSRC   = 12;
    localparam int ABRT_W = 13;
    localparam int NCLR   = 10;

    localparam int B_RX_UNDER  = 0;
    localparam int B_RX_OVER   = 1;
    localparam int B_RX_FULL   = 2;
    localparam int B_TX_OVER   = 3;
    localparam int B_TX_EMPTY  = 4;
    localparam int B_RD_REQ    = 5;
    localparam int B_TX_ABRT   = 6;
    localparam int B_RX_DONE   = 7;
    localparam int B_ACTIVITY  = 8;
    localparam int B_STOP_DET  = 9;
    localparam int B_START_DET = 10;
    localparam int B_GEN_CALL  = 11;

    typedef logic [NSRC-1:0]   src_vec_t;
    typedef logic [ABRT_W-1:0] abrt_vec_t;

    // level-following sources, everything else is sticky
    localparam src_vec_t LEVEL_SRC = src_vec_t'((1 << B_RX_FULL) | (1 << B_TX_EMPTY));
    localparam src_vec_t LATCH_SRC = ~LEVEL_SRC;

    // abort reason bits 6 and 8 are undefined
    localparam abrt_vec_t ABRT_DEFINED = abrt_vec_t'(~((1 << 6) | (1 << 8)));

    localparam int OFS_MSTAT    = 'h2C;
    localparam int OFS_MASK     = 'h30;
    localparam int OFS_RAW      = 'h34;
    localparam int OFS_CLR_ALL  = 'h40;
    localparam int OFS_CLR_BASE = 'h44;
    localparam int OFS_CLR_STEP = 4;
    localparam int OFS_ABRT     = 'h80;

    // source bit served by individual clear slot k
    function automatic int clr_slot_src(input int k);
        case (k)
            0:       return B_RX_UNDER;
            1:       return B_RX_OVER;
            2:       return B_TX_OVER;
            3:       return B_RD_REQ;
            4:       return B_TX_ABRT;
            5:       return B_RX_DONE;
            6:       return B_ACTIVITY;
            7:       return B_STOP_DET;
            8:       return B_START_DET;
            9:       return B_GEN_CALL;
            default: return B_RX_UNDER;
        endcase
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  src_vec_t          raw_q,
    input  src_vec_t          mask_q,
    input  abrt_vec_t         abrt_q,
    output logic [DATA_W-1:0] rdata,
    output src_vec_t          clr_src,
    output logic              clr_abrt,
    output logic              mask_we
);

    localparam logic [ADDR_W-1:0] A_MSTAT   = ADDR_W'(OFS_MSTAT);
    localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_RAW     = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_CLR_ALL = ADDR_W'(OFS_CLR_ALL);
    localparam logic [ADDR_W-1:0] A_ABRT    = ADDR_W'(OFS_ABRT);

    logic [NCLR-1:0] slot_hit;
    logic [NCLR-1:0] slot_val;
    src_vec_t        slot_clr [NCLR];

    for (genvar k = 0; k < NCLR; k++) begin : g_slot
        localparam int               SRC   = clr_slot_src(k);
        localparam logic [ADDR_W-1:0] SADDR = ADDR_W'(OFS_CLR_BASE + k * OFS_CLR_STEP);
        assign slot_hit[k] = (reg_addr == SADDR);
        assign slot_val[k] = raw_q[SRC];
        assign slot_clr[k] = (reg_rd && slot_hit[k]) ? src_vec_t'(1) << SRC : '0;
    end

    always_comb begin
        clr_src = '0;
        if (reg_rd && reg_addr == A_CLR_ALL) begin
            clr_src = LATCH_SRC;
        end else begin
            for (int k = 0; k < NCLR; k++) begin
                clr_src = clr_src | slot_clr[k];
            end
        end
        clr_abrt = clr_src[B_TX_ABRT];
        mask_we  = reg_wr && (reg_addr == A_MASK);
    end

    always_comb begin
        rdata = '0;
        if (reg_addr == A_MSTAT) begin
            rdata[NSRC-1:0] = raw_q & mask_q;
        end else if (reg_addr == A_MASK) begin
            rdata[NSRC-1:0] = mask_q;
        end else if (reg_addr == A_RAW) begin
            rdata[NSRC-1:0] = raw_q;
        end else if (reg_addr == A_CLR_ALL) begin
            rdata[0] = |(raw_q & LATCH_SRC);
        end else if (reg_addr == A_ABRT) begin
            rdata[ABRT_W-1:0] = abrt_q;
        end else begin
            rdata[0] = |(slot_hit & slot_val);
        end
    end

    // R4: an individual clear never touches more than one source
    a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr != A_CLR_ALL) |-> ($countones(clr_src) <= 1));

    // R11: no clear without a read strobe
    a_r11_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd) |-> (clr_src == '0));

endmodule

// File: rtl/irq_src_latch.sv
module irq_src_latch
    import irq_agg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t evt_in,
    input  logic     rx_full_lvl,
    input  logic     tx_empty_lvl,
    input  src_vec_t clr_src,
    output src_vec_t raw_q
);

    typedef struct packed {
        src_vec_t raw;
    } latch_state_t;

    latch_state_t s_d, s_q;
    src_vec_t     nxt;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (LEVEL_SRC[i]) begin : g_level
            assign nxt[i] = (i == B_RX_FULL) ? rx_full_lvl : tx_empty_lvl;
        end else begin : g_sticky
            // a new event outranks a clear in the same cycle
            assign nxt[i] = evt_in[i] | (s_q.raw[i] & ~clr_src[i]);
        end
    end

    logic unused_evt_level;
    assign unused_evt_level = ^(evt_in & LEVEL_SRC);

    always_comb begin
        s_d     = s_q;
        s_d.raw = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign raw_q = s_q.raw;

    // R7: every sticky event pulse is visible next cycle, clear or not
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_in & LATCH_SRC)) |=>
        ((raw_q & $past(evt_in & LATCH_SRC)) == $past(evt_in & LATCH_SRC)));

    // R4: bits not targeted by a clear keep their value
    a_r4_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & $past(raw_q & ~clr_src & LATCH_SRC))
                  == $past(raw_q & ~clr_src & LATCH_SRC)));

endmodule

// File: rtl/irq_abort_capture.sv
module irq_abort_capture
    import irq_agg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      abrt_evt,
    input  abrt_vec_t cause_in,
    input  logic      clr,
    output abrt_vec_t abrt_q
);

    typedef struct packed {
        abrt_vec_t why;
    } abrt_state_t;

    abrt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) s_d.why = '0;
        if (abrt_evt) s_d.why = s_d.why | (cause_in & ABRT_DEFINED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign abrt_q = s_q.why;

    // R8: undefined reason bits never set
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (abrt_q & ~ABRT_DEFINED) == '0);

    // R9: a clear with no new abort empties the register
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !abrt_evt) |=> (abrt_q == '0));

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [11:0]       evt_in,
    input  logic              rx_full_lvl,
    input  logic              tx_empty_lvl,
    input  logic [12:0]       abrt_cause,
    output logic              irq
);

    typedef struct packed {
        src_vec_t mask;
        logic     irq;
    } top_state_t;

    top_state_t s_d, s_q;
    src_vec_t   raw_q;
    abrt_vec_t  abrt_q;
    src_vec_t   clr_src;
    logic       clr_abrt;
    logic       mask_we;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NSRC];

    irq_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .raw_q    (raw_q),
        .mask_q   (s_q.mask),
        .abrt_q   (abrt_q),
        .rdata    (reg_rdata),
        .clr_src  (clr_src),
        .clr_abrt (clr_abrt),
        .mask_we  (mask_we)
    );

    irq_src_latch i_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_in       (evt_in),
        .rx_full_lvl  (rx_full_lvl),
        .tx_empty_lvl (tx_empty_lvl),
        .clr_src      (clr_src),
        .raw_q        (raw_q)
    );

    irq_abort_capture i_abort (
        .clk      (clk),
        .rst_n    (rst_n),
        .abrt_evt (evt_in[B_TX_ABRT]),
        .cause_in (abrt_cause),
        .clr      (clr_abrt),
        .abrt_q   (abrt_q)
    );

    always_comb begin
        s_d = s_q;
        if (mask_we) s_d.mask = reg_wdata[NSRC-1:0];
        s_d.irq = |(raw_q & s_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq = s_q.irq;

    // R10: interrupt line follows the masked status one cycle late
    a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(raw_q & s_q.mask)) |=> irq);
    a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|(raw_q & s_q.mask))) |=> !irq);

    // R5: combined clear with no new events empties all sticky bits
    a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(OFS_CLR_ALL) && (evt_in & LATCH_SRC) == '0)
        |=> ((raw_q & LATCH_SRC) == '0));

endmodule

// File: tb/test_irq_status_unit.sv
`timescale 1ns/1ps
module test_irq_status_unit;

    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic          reg_rd = 1'b0;
    logic [DW-1:0] reg_rdata;
    logic [11:0]   evt_in = '0;
    logic          rx_full_lvl = 1'b0;
    logic          tx_empty_lvl = 1'b0;
    logic [12:0]   abrt_cause = '0;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_status_unit #(.ADDR_W(AW), .DATA_W(DW)) i_irq_status_unit (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .evt_in(evt_in), .rx_full_lvl(rx_full_lvl), .tx_empty_lvl(tx_empty_lvl),
        .abrt_cause(abrt_cause), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] clr_addr(input int b);
        case (b)
            0: return 8'h44;  1: return 8'h48;  3: return 8'h4C;  5: return 8'h50;
            6: return 8'h54;  7: return 8'h58;  8: return 8'h5C;  9: return 8'h60;
            10: return 8'h64; 11: return 8'h68;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [11:0] bits, input logic [12:0] cause);
        @(negedge clk);
        evt_in = bits; abrt_cause = cause;
        @(negedge clk);
        evt_in = '0; abrt_cause = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'b0, irq}, 0);
        rd(8'h34, d); check("R1 raw", d, 0);
        rd(8'h30, d); check("R1 mask", d, 0);
        rd(8'h80, d); check("R1 abort", d, 0);
    endtask

    task automatic t_each_source();
        logic [31:0] d;
        for (int b = 0; b < 12; b++) begin
            if (b == 2 || b == 4) continue;
            pulse(12'(1 << b), '0);
            rd(8'h34, d); check("R2 set", d, 32'(1 << b));
            rd(clr_addr(b), d); check("R4 clear returns bit", d, 1);
            rd(8'h34, d); check("R4 cleared", d, 0);
        end
        pulse(12'h202, '0);
        rd(8'h48, d);
        rd(8'h34, d); check("R4 only target cleared", d, 32'h200);
        rd(8'h60, d);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(8'h30, 32'hFFFF_F0A5);
        rd(8'h30, d); check("R3 mask readback", d, 32'h0A5);
        pulse(12'h0AA, '0);
        rd(8'h2C, d); check("R3 masked", d, 32'h0A0);
        rd(8'h34, d); check("R3 raw", d, 32'h0AA);
        rd(8'h40, d); check("R5 combined returns any", d, 1);
        rd(8'h34, d); check("R5 all cleared", d, 0);
        rd(8'h40, d); check("R5 combined empty", d, 0);
        rd(8'h80, d); check("R9 combined clears abort", d, 0);
        wr(8'h30, 0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        @(negedge clk); rx_full_lvl = 1'b1;
        @(negedge clk);
        rd(8'h34, d); check("R6 rx level", d, 32'h004);
        rd(8'h40, d);
        rd(8'h34, d); check("R6 clear ignores level", d, 32'h004);
        pulse(12'h010, '0);
        rd(8'h34, d); check("R6 evt bit4 ignored", d, 32'h004);
        @(negedge clk); rx_full_lvl = 1'b0; tx_empty_lvl = 1'b1;
        @(negedge clk);
        rd(8'h34, d); check("R6 tx level", d, 32'h010);
        @(negedge clk); tx_empty_lvl = 1'b0;
        @(negedge clk);
        rd(8'h34, d); check("R6 level drop", d, 0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        pulse(12'h200, '0);
        @(negedge clk);
        evt_in = 12'h200; reg_addr = 8'h60; reg_rd = 1'b1;
        @(negedge clk);
        evt_in = '0; reg_rd = 1'b0;
        rd(8'h34, d); check("R7 set wins", d, 32'h200);
        rd(8'h60, d);
        rd(8'h34, d); check("R7 later clear", d, 0);
    endtask

    task automatic t_abort();
        logic [31:0] d;
        pulse(12'h040, 13'h1FFF);
        rd(8'h80, d); check("R8 defined bits only", d, 32'h1EBF);
        rd(8'h54, d);
        rd(8'h80, d); check("R9 own clear empties", d, 0);
        pulse(12'h040, 13'h0001);
        pulse(12'h040, 13'h1000);
        rd(8'h80, d); check("R8 causes OR", d, 32'h1001);
        pulse(12'h000, 13'h0008);
        rd(8'h80, d); check("R8 cause needs pulse", d, 32'h1001);
        @(negedge clk);
        evt_in = 12'h040; abrt_cause = 13'h0800; reg_addr = 8'h54; reg_rd = 1'b1;
        @(negedge clk);
        evt_in = '0; abrt_cause = '0; reg_rd = 1'b0;
        rd(8'h80, d); check("R9 new cause kept", d, 32'h0800);
        rd(8'h40, d);
        rd(8'h80, d); check("R9 combined clear", d, 0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(8'h30, 32'h001);
        pulse(12'h008, '0);
        @(negedge clk);
        check("R3 unmasked no irq", {31'b0, irq}, 0);
        pulse(12'h001, '0);
        check("R10 irq not yet", {31'b0, irq}, 0);
        @(negedge clk);
        check("R10 irq high", {31'b0, irq}, 1);
        rd(8'h44, d);
        check("R10 irq still high", {31'b0, irq}, 1);
        @(negedge clk);
        check("R10 irq low", {31'b0, irq}, 0);
        rd(8'h40, d);
        wr(8'h30, 0);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        pulse(12'h080, '0);
        wr(8'h34, 32'hFFF);
        wr(8'h58, 32'hFFF);
        rd(8'h34, d); check("R11 write ignored raw", d, 32'h080);
        rd(8'h30, d); check("R11 mask untouched", d, 0);
        rd(8'h3C, d); check("R11 unmapped reads zero", d, 0);
        rd(8'h34, d); check("R11 unmapped read no clear", d, 32'h080);
        rd(8'h58, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_each_source();
        t_mask();
        t_level();
        t_set_wins();
        t_abort();
        t_irq();
        t_ignored();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule